// File: doc/BRIEF.md
# External Interrupt Edge and Level Capture

This block turns a small set of external interrupt pins into interrupt request flags for an interrupt controller. Each pin first passes through a two-stage synchroniser into the system clock domain. Detection runs on the synchronised value, so the raw pin never reaches the detection logic.

Each pin has its own sensitivity bit and its own polarity bit. In edge mode, a transition in the chosen direction sets the pin's flag. The flag then stays set until software clears it by writing a one to its bit. In level mode, the flag is set again on every cycle that the synchronised pin sits at its active level. A held level therefore keeps requesting, and a clear cannot remove the flag while the level lasts.

Changing a pin's mode can leave a flag set from the earlier mode. Software is expected to clear the flags after every reconfiguration. If a clear and a new event reach the same flag in the same cycle, the event wins.

Top module: `eirq_capture`

## Requirements
- R1: After reset, every flag is 0, every pin is in edge mode falling, and the synchroniser chain holds 1s. Pins held high through and after reset raise no flag.
- R2: A write with `mode_we` high loads `mode_wdata` into the sensitivity bits at the next clock edge (bit value 1 = edge, 0 = level). A write with `pol_we` high loads `pol_wdata` into the polarity bits (bit value 0 = low/falling, 1 = high/rising).
- R3: In edge mode with polarity 0, a high-to-low pin transition sets that pin's flag. The flag is first visible in `irq_flag` after the third rising clock edge following the change, and is still 0 after the second.
- R4: In edge mode with polarity 1, a low-to-high pin transition sets that pin's flag, with the same three-edge latency.
- R5: In edge mode, a pin transition in the opposite direction to the selected polarity leaves the flag unchanged.
- R6: In level mode, the flag is set on every cycle the synchronised pin equals its polarity bit (low for 0, high for 1). A clear issued while the pin stays active leaves the flag at 1.
- R7: With `clr_we` high, each `clr_wdata` bit of 1 clears the matching flag at the next edge. Bits of 0 leave their flags unchanged.
- R8: When a clear and a detection event hit the same flag in the same cycle, the flag ends at 1.
- R9: A flag set under one mode stays set after that pin's mode is changed, until it is cleared.
- R10: Each pin's detection, configuration and flag are independent of the other pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | NPIN | Asynchronous external interrupt pins |
| mode_we | input | 1 | Load strobe for the sensitivity bits |
| mode_wdata | input | NPIN | Sensitivity per pin, 1 edge, 0 level |
| pol_we | input | 1 | Load strobe for the polarity bits |
| pol_wdata | input | NPIN | Polarity per pin, 0 low/falling, 1 high/rising |
| clr_we | input | 1 | Clear strobe for the flags |
| clr_wdata | input | NPIN | Write-one-to-clear mask |
| irq_flag | output | NPIN | Captured interrupt request flags |

## Verification
The bench times the three-edge latency exactly. A design that tapped the raw pin or skipped a stage would raise the flag one cycle early. A design that added a stage would raise it one cycle late.

Directed cases cover the hard interactions:
- A clear landing on the same edge as a new falling edge. A design that let the clear win would lose that interrupt.
- A clear issued while a level input is still held. A design that honoured it would drop the request.
- A mode switch with a flag pending. A design that wiped flags on reconfiguration would lose the pending request.
- Edges in the wrong direction. A design that ignored polarity would set spurious flags.

Random pin activity and random writes are then compared each cycle against a bench model.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

  localparam logic SENSE_EDGE = 1'b1;
  localparam logic POL_LOW    = 1'b0;

  // level mode: active when the synchronised pin matches the polarity bit
  function automatic logic lvl_active(input logic lvl, input logic pol);
    return lvl == pol;
  endfunction

  // edge mode: a change that lands on the polarity value
  function automatic logic edge_hit(input logic lvl, input logic old, input logic pol);
    return (lvl != old) && (lvl == pol);
  endfunction

  // flag update: a new event beats a same-cycle clear
  function automatic logic flag_upd(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int NPIN       = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_raw,
  output logic [NPIN-1:0] lvl,
  output logic [NPIN-1:0] old
);
  logic [NPIN-1:0] stg [SYNC_DEPTH];

  for (genvar s = 0; s < SYNC_DEPTH; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stg[s] <= '1;
      else if (s == 0) stg[s] <= pin_raw;
      else             stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) old <= '1;
    else        old <= stg[SYNC_DEPTH-1];
  end

  assign lvl = stg[SYNC_DEPTH-1];
endmodule

// File: rtl/eirq_detect.sv
module eirq_detect
  import eirq_pkg::*;
#(
  parameter int NPIN = 4
) (
  input  logic [NPIN-1:0] lvl,
  input  logic [NPIN-1:0] old,
  input  logic [NPIN-1:0] sense,
  input  logic [NPIN-1:0] pol,
  output logic [NPIN-1:0] set_evt
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    always_comb begin
      if (sense[i] == SENSE_EDGE) set_evt[i] = edge_hit(lvl[i], old[i], pol[i]);
      else                        set_evt[i] = lvl_active(lvl[i], pol[i]);
    end
  end
endmodule

// File: rtl/eirq_flags.sv
module eirq_flags
  import eirq_pkg::*;
#(
  parameter int NPIN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] set_evt,
  input  logic [NPIN-1:0] clr_mask,
  output logic [NPIN-1:0] flag
);
  for (genvar i = 0; i < NPIN; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag[i] <= 1'b0;
      else        flag[i] <= flag_upd(flag[i], set_evt[i], clr_mask[i]);
    end
  end
endmodule

// File: rtl/eirq_capture.sv
module eirq_capture
  import eirq_pkg::*;
#(
  parameter int NPIN       = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_raw,
  input  logic            mode_we,
  input  logic [NPIN-1:0] mode_wdata,
  input  logic            pol_we,
  input  logic [NPIN-1:0] pol_wdata,
  input  logic            clr_we,
  input  logic [NPIN-1:0] clr_wdata,
  output logic [NPIN-1:0] irq_flag
);
  logic [NPIN-1:0] mode_r;
  logic [NPIN-1:0] pol_r;
  logic [NPIN-1:0] sync_lvl;
  logic [NPIN-1:0] sync_old;
  logic [NPIN-1:0] set_evt;
  logic [NPIN-1:0] clr_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_r <= {NPIN{SENSE_EDGE}};
      pol_r  <= {NPIN{POL_LOW}};
    end else begin
      if (mode_we) mode_r <= mode_wdata;
      if (pol_we)  pol_r  <= pol_wdata;
    end
  end

  assign clr_mask = clr_we ? clr_wdata : '0;

  eirq_sync #(.NPIN(NPIN), .SYNC_DEPTH(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .lvl(sync_lvl), .old(sync_old)
  );

  eirq_detect #(.NPIN(NPIN)) u_detect (
    .lvl(sync_lvl), .old(sync_old), .sense(mode_r), .pol(pol_r), .set_evt(set_evt)
  );

  eirq_flags #(.NPIN(NPIN)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .clr_mask(clr_mask), .flag(irq_flag)
  );
endmodule

// File: rtl/eirq_capture_chk.sv
module eirq_capture_chk #(
  parameter int NPIN = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            clr_we,
  input logic [NPIN-1:0] clr_wdata,
  input logic [NPIN-1:0] mode_r,
  input logic [NPIN-1:0] pol_r,
  input logic [NPIN-1:0] sync_lvl,
  input logic [NPIN-1:0] sync_old,
  input logic [NPIN-1:0] set_evt,
  input logic [NPIN-1:0] irq_flag
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    // R7
    clr_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && clr_wdata[i] && !set_evt[i]) |=> !irq_flag[i]);
    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[i] |=> irq_flag[i]);
    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag[i] && !(clr_we && clr_wdata[i])) |=> irq_flag[i]);
    // R5
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_flag[i] && !set_evt[i]) |=> !irq_flag[i]);
    // R6
    level_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_r[i] && (sync_lvl[i] == pol_r[i])) |-> set_evt[i]);
    // R3
    fall_det_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_r[i] && !pol_r[i] && sync_old[i] && !sync_lvl[i]) |-> set_evt[i]);
    // R4
    rise_det_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_r[i] && pol_r[i] && !sync_old[i] && sync_lvl[i]) |-> set_evt[i]);
    // R5
    edge_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_r[i] && $stable(sync_lvl[i]) && (sync_old[i] == sync_lvl[i])) |-> !set_evt[i]);
  end
endmodule

bind eirq_capture eirq_capture_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_we(clr_we), .clr_wdata(clr_wdata),
  .mode_r(mode_r), .pol_r(pol_r), .sync_lvl(sync_lvl), .sync_old(sync_old),
  .set_evt(set_evt), .irq_flag(irq_flag)
);

// File: tb/eirq_capture_tb.sv
module eirq_capture_tb;
  localparam int NPIN = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NPIN-1:0] pin_raw = '1;
  logic mode_we = 1'b0, pol_we = 1'b0, clr_we = 1'b0;
  logic [NPIN-1:0] mode_wdata = '0, pol_wdata = '0, clr_wdata = '0;
  logic [NPIN-1:0] irq_flag;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  eirq_capture #(.NPIN(NPIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw),
    .mode_we(mode_we), .mode_wdata(mode_wdata),
    .pol_we(pol_we), .pol_wdata(pol_wdata),
    .clr_we(clr_we), .clr_wdata(clr_wdata),
    .irq_flag(irq_flag)
  );

  // bench model of the requirements
  logic [NPIN-1:0] m_p1, m_p2, m_p3, m_flag, m_edge, m_pol;

  function automatic bit want_event(bit edge_mode, bit pol, bit now, bit prev);
    if (!edge_mode) return pol ? now : !now;
    if (pol) return now && !prev;
    return prev && !now;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_p1 <= '1; m_p2 <= '1; m_p3 <= '1;
      m_flag <= '0; m_edge <= '1; m_pol <= '0;
    end else begin
      for (int i = 0; i < NPIN; i++) begin
        if (want_event(m_edge[i], m_pol[i], m_p2[i], m_p3[i])) m_flag[i] <= 1'b1;
        else if (clr_we && clr_wdata[i])                        m_flag[i] <= 1'b0;
      end
      m_p1 <= pin_raw; m_p2 <= m_p1; m_p3 <= m_p2;
      if (mode_we) m_edge <= mode_wdata;
      if (pol_we)  m_pol  <= pol_wdata;
    end
  end

  task automatic check(input string tag, input logic [NPIN-1:0] act, input logic [NPIN-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flags(input logic [NPIN-1:0] m);
    clr_we = 1'b1; clr_wdata = m;
    cyc(1);
    clr_we = 1'b0; clr_wdata = '0;
  endtask

  task automatic wr_mode(input logic [NPIN-1:0] v);
    mode_we = 1'b1; mode_wdata = v; cyc(1); mode_we = 1'b0;
  endtask

  task automatic wr_pol(input logic [NPIN-1:0] v);
    pol_we = 1'b1; pol_wdata = v; cyc(1); pol_we = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    cyc(3);
    rst_n = 1'b1;
    cyc(5);
    check("R1 reset flags", irq_flag, 4'b0000);

    // R3 falling edge on pin 0, latency
    pin_raw = 4'b1110;
    cyc(2);
    check("R3 not before third edge", irq_flag, 4'b0000);
    cyc(1);
    check("R3 falling edge flag", irq_flag, 4'b0001);
    check("R10 other pins untouched", irq_flag & 4'b1110, 4'b0000);
    clear_flags(4'b0001);
    check("R7 clear by one", irq_flag, 4'b0000);

    // R7 zero bits keep flags
    pin_raw = 4'b1100;
    cyc(3);
    check("R3 pin1 falling", irq_flag, 4'b0010);
    clear_flags(4'b1101);
    check("R7 zero bit keeps flag", irq_flag, 4'b0010);
    clear_flags(4'b0010);

    // R5 rising with polarity 0
    pin_raw = 4'b1111;
    cyc(4);
    check("R5 rising ignored pol0", irq_flag, 4'b0000);

    // R4 / R2 polarity 1 on pin 2
    wr_pol(4'b0100);
    pin_raw = 4'b1011;
    cyc(4);
    check("R5 falling ignored pol1", irq_flag, 4'b0000);
    pin_raw = 4'b1111;
    cyc(2);
    check("R4 not before third edge", irq_flag, 4'b0000);
    cyc(1);
    check("R4 rising edge flag R2", irq_flag, 4'b0100);
    clear_flags(4'b0100);

    // R6 level mode on pin 3, low active
    wr_pol(4'b0000);
    wr_mode(4'b0111);
    cyc(3);
    check("R6 inactive level no flag R2", irq_flag, 4'b0000);
    pin_raw = 4'b0111;
    cyc(3);
    check("R6 level flag", irq_flag, 4'b1000);
    clear_flags(4'b1000);
    check("R6 clear blocked while active", irq_flag, 4'b1000);
    pin_raw = 4'b1111;
    cyc(4);
    clear_flags(4'b1000);
    check("R6 clear after release", irq_flag, 4'b0000);

    // R9 mode change keeps pending flag
    pin_raw = 4'b0111;
    cyc(4);
    wr_mode(4'b1111);
    pin_raw = 4'b1111;
    cyc(5);
    check("R9 flag survives mode change", irq_flag, 4'b1000);
    clear_flags(4'b1000);
    check("R9 cleared afterwards", irq_flag, 4'b0000);

    // R8 clear on the same edge as a falling event on pin 0
    pin_raw = 4'b1110;
    cyc(3);
    pin_raw = 4'b1111;
    cyc(4);
    check("R8 setup flag", irq_flag, 4'b0001);
    pin_raw = 4'b1110;
    cyc(2);
    clr_we = 1'b1; clr_wdata = 4'b0001;
    cyc(1);
    clr_we = 1'b0; clr_wdata = '0;
    check("R8 event beats clear", irq_flag, 4'b0001);
    clear_flags(4'b1111);
    pin_raw = 4'b1111;
    cyc(4);
    clear_flags(4'b1111);

    // R10 random phase against the bench model
    for (int k = 0; k < 4000; k++) begin
      check("R10 random model", irq_flag, m_flag);
      if (($urandom % 3) == 0) pin_raw = pin_raw ^ NPIN'($urandom);
      mode_we    = (($urandom % 40) == 0);
      mode_wdata = NPIN'($urandom);
      pol_we     = (($urandom % 40) == 0);
      pol_wdata  = NPIN'($urandom);
      clr_we     = (($urandom % 6) == 0);
      clr_wdata  = NPIN'($urandom);
      cyc(1);
    end
    mode_we = 1'b0; pol_we = 1'b0; clr_we = 1'b0;
    cyc(1);
    check("R10 random final", irq_flag, m_flag);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule